// File: doc/BRIEF.md
# Multicycle Multiply-Divide Unit

This block is the sequential arithmetic engine beside a small CPU's ALU. It runs five operations. Two are unsigned multiplies: a byte form (8x8 to 16) and a word form (16x16 to 32). Two are signed multiplies in the same byte and word forms. The fifth is an unsigned divide of a 16-bit dividend by an 8-bit divisor. Each operation takes a fixed number of cycles that does not depend on the data, so the pipeline around the unit can schedule the write-back without waiting on a handshake. Multiplies use an iterative shift-add on operand magnitudes, with a negation at the end for the signed forms. The divide is a restoring divide, one quotient bit per cycle. Once the arithmetic is finished, idle cycles pad each operation out to its latency.

The input side is a valid/ready pair. An operation is taken when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` stays low from that edge up to and including the cycle in which `done` is high, so back-pressure is simply the unit being busy. The output side has no back-pressure: `done` is a one-cycle strobe, and `result`, `flag_n`, `flag_z` and `flags_we` are meaningful in that cycle. The latency of an operation counts the cycle in which it is accepted as its first state, so `done` is high in state number L.

Top module: `muldiv_unit`

## Requirements
- R1: Opcode 0 (unsigned byte multiply) gives `result[15:0]` = `in_dst[7:0]` * `in_src[7:0]`, with `result[31:16]` zero. The upper operand bytes are ignored. `done` is high in state 14.
- R2: Opcode 1 (unsigned word multiply) gives `result` = `in_dst` * `in_src` as a 32-bit product. `done` is high in state 22.
- R3: Opcode 2 (signed byte multiply) gives `result[15:0]` = the two's-complement product of `in_dst[7:0]` and `in_src[7:0]`, with `result[31:16]` zero. `done` is high in state 16.
- R4: Opcode 3 (signed word multiply) gives `result` = the 32-bit two's-complement product of `in_dst` and `in_src`. `done` is high in state 24.
- R5: Opcode 4 (unsigned divide) uses `in_dst` as the dividend and `in_src[7:0]` as the divisor. When the divisor is nonzero and `in_dst[15:8]` is below it, `result[15:8]` is the remainder, `result[7:0]` is the quotient and `result[31:16]` is zero. `done` is high in state 14.
- R6: The unsigned multiplies hold `flags_we` low in their `done` cycle, so no flag is updated.
- R7: The signed multiplies raise `flags_we`. `flag_n` is the product's sign bit (bit 15 for byte, bit 31 for word), and `flag_z` is high when the product is zero.
- R8: The divide raises `flags_we`, with `flag_n` = divisor bit 7 and `flag_z` high when the divisor is zero. A zero divisor still produces `done` in state 14.
- R9: `done` is high for exactly one cycle per operation. `in_ready` is low from acceptance through the `done` cycle and high in the following cycle.
- R10: `in_valid` while `in_ready` is low is ignored: the running operation's latency and result are unchanged.
- R11: During and after reset, `in_ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit idle; request taken when both high |
| in_op | input | 3 | Opcode 0..4 as in R1-R5 (5..7 reserved) |
| in_src | input | 16 | Source operand (multiplier or divisor) |
| in_dst | input | 16 | Destination operand (multiplicand or dividend) |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Product, or remainder:quotient in bits 15:0 |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flags_we | output | 1 | Flag update enable, valid with done |

## Verification
On every cycle the assertions check the following: the single-cycle `done` and the return to idle after it, the counter advancing without gaps while busy, the restoring divide keeping its partial remainder below the divisor, the sign of signed products against the operand signs, the zero upper half on byte results, and unsigned multiplies never enabling flags. What only the bench scenarios can show is that every product and quotient is numerically correct, that each opcode's latency matches its state count exactly, and that a request arriving mid-operation disturbs neither. The bench covers these with corner-value cross products (0, 1, most-negative, all-ones and neighbours), random operands and zero-divisor runs.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    MD_MULU_B = 3'd0,
    MD_MULU_W = 3'd1,
    MD_MULS_B = 3'd2,
    MD_MULS_W = 3'd3,
    MD_DIVU_B = 3'd4
  } md_op_e;

  function automatic logic md_is_word(input md_op_e op);
    return (op == MD_MULU_W) || (op == MD_MULS_W);
  endfunction

  function automatic logic md_is_smul(input md_op_e op);
    return (op == MD_MULS_B) || (op == MD_MULS_W);
  endfunction
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] lat,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] lat_q;

  // cnt = 1 in the first cycle after acceptance; done in state lat
  assign done = busy && (cnt == lat_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      lat_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= CNT_W'(1);
      lat_q <= lat;
    end else if (busy) begin
      cnt <= cnt + CNT_W'(1);
      if (done) busy <= 1'b0;
    end
  end

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_count_gapless_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplr,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] mc_q;
  logic [W:0]   sum;

  // add multiplicand into the upper half when the current multiplier bit is 1
  assign sum = {1'b0, prod[2*W-1:W]} + (prod[0] ? {1'b0, mc_q} : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
      prod <= '0;
    end else if (load) begin
      mc_q <= mcand;
      prod <= {{W{1'b0}}, mplr};
    end else if (step) begin
      prod <= {sum, prod[W-1:1]};
    end
  end

  p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (prod[2*W-1:W] == '0));
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int H = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [2*H-1:0] dividend,
  input  logic [H-1:0]   divisor,
  output logic [2*H-1:0] rem_quo
);
  logic [H-1:0] hi, lo, dv;
  logic [H+1:0] trial;

  assign trial   = {1'b0, hi, lo[H-1]} - {2'b00, dv};
  assign rem_quo = {hi, lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi <= '0;
      lo <= '0;
      dv <= '0;
    end else if (load) begin
      hi <= dividend[2*H-1:H];
      lo <= dividend[H-1:0];
      dv <= divisor;
    end else if (step) begin
      hi <= trial[H+1] ? {hi[H-2:0], lo[H-1]} : trial[H-1:0];
      lo <= {lo[H-2:0], ~trial[H+1]};
    end
  end

  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hi < dv) |=> (hi < dv));
  p_trial_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hi < dv && !trial[H+1]) |-> !trial[H]);
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int W          = 16,
  parameter int LAT_MULU_B = 14,
  parameter int LAT_MULU_W = 22,
  parameter int LAT_MULS_B = 16,
  parameter int LAT_MULS_W = 24,
  parameter int LAT_DIVU_B = 14,
  parameter int CNT_W      = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     in_op,
  input  logic [W-1:0]   in_src,
  input  logic [W-1:0]   in_dst,
  output logic           done,
  output logic [2*W-1:0] result,
  output logic           flag_n,
  output logic           flag_z,
  output logic           flags_we
);
  localparam int H = W / 2;

  md_op_e           op_in, op_q;
  logic             busy, accept, step, neg_in, neg_q;
  logic [CNT_W-1:0] cnt, lat_sel, nbits;
  logic [W-1:0]     src_q, dst_q, mc_in, mp_in, mag_b, sres_b;
  logic [2*W-1:0]   prod;
  logic [W-1:0]     rq;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  always_comb begin
    unique case (in_op)
      3'd0:    begin op_in = MD_MULU_B; lat_sel = CNT_W'(LAT_MULU_B); end
      3'd1:    begin op_in = MD_MULU_W; lat_sel = CNT_W'(LAT_MULU_W); end
      3'd2:    begin op_in = MD_MULS_B; lat_sel = CNT_W'(LAT_MULS_B); end
      3'd3:    begin op_in = MD_MULS_W; lat_sel = CNT_W'(LAT_MULS_W); end
      default: begin op_in = MD_DIVU_B; lat_sel = CNT_W'(LAT_DIVU_B); end
    endcase
  end

  // operand magnitudes for the shift-add engine
  always_comb begin
    if (md_is_word(op_in)) begin
      mc_in  = (md_is_smul(op_in) && in_dst[W-1]) ? W'(0) - in_dst : in_dst;
      mp_in  = (md_is_smul(op_in) && in_src[W-1]) ? W'(0) - in_src : in_src;
      neg_in = md_is_smul(op_in) && (in_dst[W-1] ^ in_src[W-1]);
    end else begin
      mc_in  = {{H{1'b0}}, (md_is_smul(op_in) && in_dst[H-1]) ? H'(0) - in_dst[H-1:0] : in_dst[H-1:0]};
      mp_in  = {{H{1'b0}}, (md_is_smul(op_in) && in_src[H-1]) ? H'(0) - in_src[H-1:0] : in_src[H-1:0]};
      neg_in = md_is_smul(op_in) && (in_dst[H-1] ^ in_src[H-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= MD_MULU_B;
      neg_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
    end else if (accept) begin
      op_q  <= op_in;
      neg_q <= neg_in;
      src_q <= in_src;
      dst_q <= in_dst;
    end
  end

  assign nbits = md_is_word(op_q) ? CNT_W'(W) : CNT_W'(H);
  assign step  = busy && (cnt <= nbits);

  mdu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .lat(lat_sel),
    .busy(busy), .done(done), .cnt(cnt)
  );

  mdu_mul #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .step(step && op_q != MD_DIVU_B),
    .mcand(mc_in), .mplr(mp_in), .prod(prod)
  );

  mdu_div #(.H(H)) u_div (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .step(step && op_q == MD_DIVU_B),
    .dividend(in_dst), .divisor(in_src[H-1:0]), .rem_quo(rq)
  );

  // byte products land shifted up by H after H steps
  assign mag_b  = prod[W+H-1:H];
  assign sres_b = neg_q ? W'(0) - mag_b : mag_b;

  always_comb begin
    flags_we = 1'b0;
    flag_n   = 1'b0;
    flag_z   = 1'b0;
    unique case (op_q)
      MD_MULU_B: result = {{W{1'b0}}, mag_b};
      MD_MULU_W: result = prod;
      MD_MULS_B: begin
        result   = {{W{1'b0}}, sres_b};
        flags_we = 1'b1;
        flag_n   = sres_b[W-1];
        flag_z   = (sres_b == '0);
      end
      MD_MULS_W: begin
        result   = neg_q ? (2*W)'(0) - prod : prod;
        flags_we = 1'b1;
        flag_n   = result[2*W-1];
        flag_z   = (result == '0);
      end
      default: begin
        result   = {{W{1'b0}}, rq};
        flags_we = 1'b1;
        flag_n   = src_q[H-1];
        flag_z   = (src_q[H-1:0] == '0);
      end
    endcase
  end

  p_byte_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == MD_MULU_B) |-> (result[2*W-1:W] == '0));
  p_unsigned_noflags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == MD_MULU_B || op_q == MD_MULU_W)) |-> !flags_we);
  p_sbyte_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == MD_MULS_B && src_q[H-1:0] != '0 && dst_q[H-1:0] != '0)
      |-> (result[W-1] == (src_q[H-1] ^ dst_q[H-1])));
  p_sword_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == MD_MULS_W && src_q != '0 && dst_q != '0)
      |-> (result[2*W-1] == (src_q[W-1] ^ dst_q[W-1])));
  p_div_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == MD_DIVU_B && dst_q[W-1:H] < src_q[H-1:0])
      |-> (result[W-1:H] < src_q[H-1:0]));
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ($stable(op_q) && $stable(src_q) && $stable(dst_q)));
endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, done, flag_n, flag_z, flags_we;
  logic [2:0]  in_op;
  logic [15:0] in_src, in_dst;
  logic [31:0] result;
  int          checks = 0, fails = 0;
  longint      cyc = 0;

  always #5 clk = ~clk;

  muldiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src(in_src), .in_dst(in_dst), .done(done),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flags_we(flags_we)
  );

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input int op, input logic [15:0] s, input logic [15:0] d, input bit poke);
    longint a, b, p;
    logic [31:0] er;
    int lat, k;
    bit chk_res, ewe, en, ez;
    string rq, rf;
    chk_res = 1; ewe = 0; en = 0; ez = 0; er = '0;
    case (op)
      0: begin a = longint'(d[7:0]); b = longint'(s[7:0]); p = a * b;
               er = 32'(p); lat = 14; rq = "R1"; rf = "R6"; end
      1: begin a = longint'(d); b = longint'(s); p = a * b;
               er = 32'(p); lat = 22; rq = "R2"; rf = "R6"; end
      2: begin a = longint'($signed(d[7:0])); b = longint'($signed(s[7:0])); p = a * b;
               er = {16'h0, 16'(p)}; lat = 16; rq = "R3"; rf = "R7";
               ewe = 1; en = er[15]; ez = (er == 0); end
      3: begin a = longint'($signed(d)); b = longint'($signed(s)); p = a * b;
               er = 32'(p); lat = 24; rq = "R4"; rf = "R7";
               ewe = 1; en = er[31]; ez = (er == 0); end
      default: begin
        lat = 14; rq = "R5"; rf = "R8"; ewe = 1; en = s[7]; ez = (s[7:0] == 0);
        if (s[7:0] != 0 && d[15:8] < s[7:0]) begin
          a = longint'(d) / longint'(s[7:0]);
          b = longint'(d) % longint'(s[7:0]);
          er = {16'h0, 8'(b), 8'(a)};
        end else chk_res = 0;
      end
    endcase
    if (poke) rq = "R10";
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'(op); in_src = s; in_dst = d;
    @(negedge clk);
    in_valid = 1'b0;
    k = 1;
    while (!done && k < 40) begin
      if (poke && k == 3) begin
        in_valid = 1'b1; in_op = 3'd1; in_src = 16'hFFFF; in_dst = 16'hFFFF;
      end else in_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    in_valid = 1'b0;
    check(k + 1 == lat, {rq, " latency"}, k + 1, lat);
    if (chk_res) check(result == er, {rq, " result"}, result, er);
    check(flags_we == ewe, {rf, " flags_we"}, flags_we, ewe);
    if (ewe) begin
      check(flag_n == en, {rf, " flag_n"}, flag_n, en);
      check(flag_z == ez, {rf, " flag_z"}, flag_z, ez);
    end
    check(in_ready == 1'b0, "R9 ready low at done", in_ready, 0);
    @(negedge clk);
    check(done == 1'b0 && in_ready == 1'b1, "R9 single done then ready", {done, in_ready}, 2'b01);
  endtask

  logic [7:0]  cb [8] = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};
  logic [15:0] cw [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF, 16'h00FF, 16'h5A5A};

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_src = '0; in_dst = '0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && done == 1'b0, "R11 reset state", {in_ready, done}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && done == 1'b0, "R11 after reset", {in_ready, done}, 2'b10);

    // corner cross products, byte ops with random upper bytes (ignored)
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          if (op == 1 || op == 3) run_op(op, cw[j], cw[i], 0);
          else run_op(op, {8'($urandom), cb[j]}, {8'($urandom), cb[i]}, 0);
        end
    for (int op = 0; op < 4; op++)
      for (int n = 0; n < 150; n++)
        run_op(op, 16'($urandom), 16'($urandom), 0);

    // divide: corner divisors with in-range dividends, then random
    for (int j = 1; j < 8; j++)
      for (int n = 0; n < 8; n++)
        run_op(4, {8'($urandom), cb[j]}, {8'($urandom % cb[j]), 8'($urandom)}, 0);
    for (int n = 0; n < 150; n++) begin
      logic [7:0] dv;
      dv = 8'($urandom % 255) + 8'd1;
      run_op(4, {8'($urandom), dv}, {8'($urandom % dv), 8'($urandom)}, 0);
    end
    run_op(4, 16'h0004, 16'h0003, 0);
    run_op(4, 16'h00FF, 16'hFEFF, 0);
    // zero divisor: must still complete (R8)
    for (int n = 0; n < 4; n++) run_op(4, {8'($urandom), 8'h00}, 16'($urandom), 0);

    // requests while busy are ignored (R10)
    for (int op = 0; op < 5; op++)
      for (int n = 0; n < 4; n++)
        run_op(op, {8'($urandom), 8'($urandom % 200 + 20)}, {8'($urandom % 20), 8'($urandom)}, 1);

    finish_run();
  end
endmodule